// File: doc/BRIEF.md
# Auxiliary RAM bank select

This block sits beside the CPU address bus and decides, for every access in the lower 48K of the address space, whether the access goes to the main 64K RAM or to the auxiliary 64K RAM. The decision depends on five mode flags. Software sets or clears each flag by touching a fixed I/O address, and bit 0 of that address gives the new value. The flags cover four things: an alternate zero page and stack, separate read and write banks for the general area, a split mode that lets the display page flag steer the text window, and the display page flag itself.

The bank decision is combinational and applies to the access that is on the bus. Flag changes are registered, so they apply from the next clock edge. A read of one of five status addresses returns the state of one flag in bit 7 of a data byte, together with a valid flag, one cycle after the read.

Top module: `auxbank_sel`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all five flags. After reset every access below $C000 selects main RAM (use_aux = 0), and stat_valid is 0.
- R2: A write (acc_write = 1) to $C000/$C001 sets the split flag, to $C002/$C003 the read-bank flag, to $C004/$C005 the write-bank flag and to $C008/$C009 the zero-page flag, each to address bit 0. A read of these addresses leaves the flags unchanged.
- R3: A read or a write of $C054/$C055 sets the display page flag to address bit 0.
- R4: Accesses to $0000–$01FF, reads and writes alike, select auxiliary RAM exactly when the zero-page flag is 1.
- R5: Outside the text window when split mode is on, reads of $0200–$BFFF select auxiliary RAM when the read-bank flag is 1, and writes when the write-bank flag is 1.
- R6: With the split flag at 1, reads and writes of $0400–$07FF select auxiliary RAM exactly when the display page flag is 1, whatever the read-bank and write-bank flags hold.
- R7: The graphics window $2000–$3FFF follows the read-bank flag for reads and the write-bank flag for writes even with the split flag and the display page flag at 1.
- R8: A read of $C013, $C014, $C016, $C018 or $C01C gives, in the next cycle, stat_valid = 1 and stat_data with bit 7 equal to the read-bank, write-bank, zero-page, split or display page flag respectively and bits 6..0 zero. Any other access, including a write to a status address, gives stat_valid = 0 and stat_data = 0 in the next cycle.
- R9: A flag change takes effect from the clock edge that ends the access making it. The access after that edge sees the new value, and the bank decision of the changing access itself uses the old values.
- R10: use_aux is 0 when acc_valid is 0 and for any address at or above $C000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access is on the bus this cycle |
| acc_addr | input | 16 | CPU address of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| use_aux | output | 1 | 1 when the current access goes to auxiliary RAM |
| stat_valid | output | 1 | Status byte valid, one cycle after a status read |
| stat_data | output | 8 | Status byte, flag in bit 7 |

## Verification
The bank decision is due in the same cycle as the access, so the bench drives each access just after a falling edge and samples use_aux one nanosecond later, before the rising edge that ends it. The status byte is due one cycle later, and the bench samples it one nanosecond after that rising edge. Flag effects are due from the following access, so every flag change is checked through the bank decision or the status byte of a later access. The bench never checks a flag change on the access that makes it.

// File: rtl/auxbank_pkg.sv
package auxbank_pkg;

    localparam int ADDR_W = 16;

    typedef struct packed {
        logic split80;
        logic rd_aux;
        logic wr_aux;
        logic zp_aux;
        logic page_sel;
    } bank_flags_t;

    localparam int NUM_STAT = 5;

    // status addresses, in the order of the flag vector built by stat_vec()
    localparam logic [ADDR_W-1:0] STAT_ADDR [NUM_STAT] = '{
        16'hC013, 16'hC014, 16'hC016, 16'hC018, 16'hC01C
    };

    localparam logic [ADDR_W-1:0] SW_SPLIT  = 16'hC000;
    localparam logic [ADDR_W-1:0] SW_RDBANK = 16'hC002;
    localparam logic [ADDR_W-1:0] SW_WRBANK = 16'hC004;
    localparam logic [ADDR_W-1:0] SW_ZPBANK = 16'hC008;
    localparam logic [ADDR_W-1:0] SW_PAGE   = 16'hC054;

    localparam logic [ADDR_W-1:0] ZP_HI   = 16'h01FF;
    localparam logic [ADDR_W-1:0] TXT_LO  = 16'h0400;
    localparam logic [ADDR_W-1:0] TXT_HI  = 16'h07FF;
    localparam logic [ADDR_W-1:0] GEN_HI  = 16'hBFFF;

    function automatic logic [NUM_STAT-1:0] stat_vec(input bank_flags_t f);
        return {f.page_sel, f.split80, f.zp_aux, f.wr_aux, f.rd_aux};
    endfunction

    function automatic logic same_pair(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base);
        return a[ADDR_W-1:1] == base[ADDR_W-1:1];
    endfunction

endpackage

// File: rtl/auxbank_flags.sv
module auxbank_flags
    import auxbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output bank_flags_t       flags_q
);

    bank_flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (acc_valid && acc_write) begin
            if (same_pair(acc_addr, SW_SPLIT))  flags_d.split80 = acc_addr[0];
            if (same_pair(acc_addr, SW_RDBANK)) flags_d.rd_aux  = acc_addr[0];
            if (same_pair(acc_addr, SW_WRBANK)) flags_d.wr_aux  = acc_addr[0];
            if (same_pair(acc_addr, SW_ZPBANK)) flags_d.zp_aux  = acc_addr[0];
        end
        // the page flag answers to reads as well as writes
        if (acc_valid && same_pair(acc_addr, SW_PAGE)) begin
            flags_d.page_sel = acc_addr[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/auxbank_route.sv
module auxbank_route
    import auxbank_pkg::*;
(
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  bank_flags_t       flags_q,
    output logic              use_aux
);

    logic in_zp;
    logic in_gen;
    logic in_txt;
    logic dir_sel;

    always_comb begin
        in_zp   = acc_addr <= ZP_HI;
        in_gen  = (acc_addr > ZP_HI) && (acc_addr <= GEN_HI);
        in_txt  = (acc_addr >= TXT_LO) && (acc_addr <= TXT_HI);
        dir_sel = acc_write ? flags_q.wr_aux : flags_q.rd_aux;

        use_aux = 1'b0;
        if (acc_valid) begin
            if (in_zp) begin
                use_aux = flags_q.zp_aux;
            end else if (in_txt && flags_q.split80) begin
                use_aux = flags_q.page_sel;
            end else if (in_gen) begin
                use_aux = dir_sel;
            end
        end
    end

endmodule

// File: rtl/auxbank_status.sv
module auxbank_status
    import auxbank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  bank_flags_t       flags_q,
    output logic              stat_valid,
    output logic [DATA_W-1:0] stat_data
);

    localparam int FLAG_BIT = DATA_W - 1;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } stat_t;

    stat_t stat_d, stat_q;
    logic [NUM_STAT-1:0] hit;
    logic [NUM_STAT-1:0] fvec;

    assign fvec = stat_vec(flags_q);

    for (genvar i = 0; i < NUM_STAT; i++) begin : g_hit
        assign hit[i] = acc_valid && !acc_write && (acc_addr == STAT_ADDR[i]);
    end

    always_comb begin
        stat_d = '0;
        stat_d.valid = |hit;
        stat_d.data[FLAG_BIT] = |(hit & fvec);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_valid = stat_q.valid;
    assign stat_data  = stat_q.data;

endmodule

// File: rtl/auxbank_sel.sv
module auxbank_sel
    import auxbank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              use_aux,
    output logic              stat_valid,
    output logic [DATA_W-1:0] stat_data
);

    bank_flags_t flags_q;

    auxbank_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .flags_q   (flags_q)
    );

    auxbank_route u_route (
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .flags_q   (flags_q),
        .use_aux   (use_aux)
    );

    auxbank_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_addr   (acc_addr),
        .acc_write  (acc_write),
        .flags_q    (flags_q),
        .stat_valid (stat_valid),
        .stat_data  (stat_data)
    );

endmodule

// File: rtl/auxbank_chk.sv
module auxbank_chk
    import auxbank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              use_aux,
    input  logic              stat_valid,
    input  logic [DATA_W-1:0] stat_data,
    input  bank_flags_t       flags_q
);

    // R1: reset leaves no status pending and all flags clear
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!stat_valid && flags_q == '0));

    // R2: write-bank flag follows a write to its odd switch address
    p_wrbank_set_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_addr == 16'hC005) |=> flags_q.wr_aux);

    // R3: page flag cleared by any access to the even page address
    p_page_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr == 16'hC054) |=> !flags_q.page_sel);

    // R4: zero page follows the zero-page flag
    p_zp_route_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr <= 16'h01FF) |-> (use_aux == flags_q.zp_aux));

    // R6: split mode routes the text window by page flag
    p_text_route_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && flags_q.split80 && acc_addr >= 16'h0400 && acc_addr <= 16'h07FF)
        |-> (use_aux == flags_q.page_sel));

    // R8: status byte carries only bit 7
    p_stat_bits_r8: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> (stat_data[DATA_W-2:0] == '0));

    // R8: no status without a read of a status address
    p_stat_none_r8: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid || acc_write) |=> !stat_valid);

    // R9: flags hold when there is no access
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> $stable(flags_q));

    // R10: nothing above the general area, nothing when idle
    p_high_main_r10: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid || acc_addr >= 16'hC000) |-> !use_aux);

endmodule

bind auxbank_sel auxbank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_write  (acc_write),
    .use_aux    (use_aux),
    .stat_valid (stat_valid),
    .stat_data  (stat_data),
    .flags_q    (flags_q)
);

// File: tb/auxbank_sel_test.sv
`timescale 1ns/1ps
module auxbank_sel_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [15:0] acc_addr;
    logic        acc_write;
    logic        use_aux;
    logic        stat_valid;
    logic [7:0]  stat_data;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    auxbank_sel uut (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_addr   (acc_addr),
        .acc_write  (acc_write),
        .use_aux    (use_aux),
        .stat_valid (stat_valid),
        .stat_data  (stat_data)
    );

    logic aux_s;
    logic sv_s;
    logic [7:0] sd_s;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one access: bank decision sampled before the closing edge, status after it
    task automatic acc(input logic v, input logic [15:0] a, input logic w);
        @(negedge clk);
        acc_valid = v;
        acc_addr  = a;
        acc_write = w;
        #1 aux_s = use_aux;
        @(posedge clk);
        #1;
        sv_s = stat_valid;
        sd_s = stat_data;
        acc_valid = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);  acc(1'b1, a, 1'b0); endtask
    task automatic wr(input logic [15:0] a);  acc(1'b1, a, 1'b1); endtask

    task automatic stat(input string req, input logic [15:0] a, input int exp);
        rd(a);
        chk({req, " valid"}, sv_s, 1);
        chk({req, " data"}, sd_s, exp);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        acc_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        do_reset();
        chk("R1 stat_valid", stat_valid, 0);
        rd(16'h0100); chk("R1 zp read", aux_s, 0);
        wr(16'h0300); chk("R1 gen write", aux_s, 0);
        rd(16'h0500); chk("R1 text read", aux_s, 0);
        stat("R1 rd flag", 16'hC013, 8'h00);
        stat("R1 wr flag", 16'hC014, 8'h00);
        stat("R1 zp flag", 16'hC016, 8'h00);
        stat("R1 split flag", 16'hC018, 8'h00);
        stat("R1 page flag", 16'hC01C, 8'h00);
    endtask

    task automatic t_zero_page;
        wr(16'hC009); chk("R10 switch access", aux_s, 0);
        rd(16'h0000); chk("R4 zp read on", aux_s, 1);
        wr(16'h01FF); chk("R4 zp write on", aux_s, 1);
        rd(16'h0200); chk("R5 just above zp", aux_s, 0);
        acc(1'b0, 16'h0000, 1'b0); chk("R10 idle bus", aux_s, 0);
        stat("R8 zp flag", 16'hC016, 8'h80);
        rd(16'hC008); // a read must not clear it
        rd(16'h0080); chk("R2 read of switch ignored", aux_s, 1);
        wr(16'hC008);
        rd(16'h0080); chk("R4 zp off", aux_s, 0);
    endtask

    task automatic t_general;
        rd(16'hC003); // read: ignored
        stat("R2 read ignored rd flag", 16'hC013, 8'h00);
        wr(16'hC003); chk("R9 changing access", aux_s, 0);
        rd(16'h0300); chk("R9 next access sees new", aux_s, 1);
        wr(16'h0300); chk("R5 write with wr off", aux_s, 0);
        stat("R8 rd flag", 16'hC013, 8'h80);
        wr(16'hC005);
        wr(16'hBFFF); chk("R5 write top", aux_s, 1);
        stat("R8 wr flag", 16'hC014, 8'h80);
        wr(16'hC002);
        rd(16'hBFFF); chk("R5 read rd off", aux_s, 0);
        rd(16'hC000); chk("R10 io region", aux_s, 0);
        wr(16'hC004);
    endtask

    task automatic t_text;
        wr(16'hC003);                         // rd on, wr off, split off
        rd(16'h0400); chk("R5 text read split off", aux_s, 1);
        wr(16'h07FF); chk("R5 text write split off", aux_s, 0);
        wr(16'hC001);
        stat("R8 split flag", 16'hC018, 8'h80);
        rd(16'h0400); chk("R6 split page off read", aux_s, 0);
        rd(16'hC055); chk("R10 page switch access", aux_s, 0);
        rd(16'h0400); chk("R6 split page on read", aux_s, 1);
        wr(16'h07FF); chk("R6 split page on write", aux_s, 1);
        rd(16'h03FF); chk("R5 below text window", aux_s, 1);
        wr(16'h0800); chk("R5 above text window", aux_s, 0);
        rd(16'h2000); chk("R7 graphics read", aux_s, 1);
        wr(16'h3FFF); chk("R7 graphics write", aux_s, 0);
        stat("R8 page flag", 16'hC01C, 8'h80);
        wr(16'hC054);
        stat("R3 page cleared by write", 16'hC01C, 8'h00);
        rd(16'h0400); chk("R6 split page off again", aux_s, 0);
        wr(16'hC055);
        stat("R3 page set by write", 16'hC01C, 8'h80);
        wr(16'hC000);
        wr(16'h0400); chk("R6 split off write follows wr", aux_s, 0);
    endtask

    task automatic t_status_misc;
        wr(16'hC013); chk("R8 write to status addr", sv_s, 0);
        rd(16'hC015); chk("R8 other address", sv_s, 0);
        chk("R8 other data", sd_s, 0);
        rd(16'h0010); chk("R8 memory read", sv_s, 0);
    endtask

    task automatic t_reset_again;
        wr(16'hC009); wr(16'hC001); rd(16'hC055); wr(16'hC005);
        do_reset();
        rd(16'h0010); chk("R1 zp after reset", aux_s, 0);
        wr(16'h0600); chk("R1 text after reset", aux_s, 0);
        stat("R1 page after reset", 16'hC01C, 8'h00);
        stat("R1 rd after reset", 16'hC013, 8'h00);
    endtask

    initial begin
        rst = 1'b1;
        acc_valid = 1'b0;
        acc_addr = '0;
        acc_write = 1'b0;
        t_reset();
        t_zero_page();
        t_general();
        t_text();
        t_status_misc();
        t_reset_again();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule